// File: doc/BRIEF.md
# Packet Event Statistics Counters with Coherent Snapshot

This block keeps six wide event counters for a packet client: start-of-packet, end-of-packet and error events, each for the transmit stream and for the receive stream. Each stream presents a valid strobe together with its SOP, EOP and error flags. A counter advances by one in every cycle where its stream's valid is high and its own flag is high. All six counters run freely and never stop. They wrap at their full width and never saturate.

Software reads the counters through a word-wide read port. Each counter is split into a low word and a high word. The read port never looks at the live counters. It returns shadow copies that a snapshot request loads from all six live counters on one clock edge. Both words of a counter therefore come from the same instant, even though counting goes on in the meantime. A flag tells software that a snapshot is held. Two clear inputs, a general clear and an end-of-packet clear, zero the live counters, the shadows and the flag.

Top module: `pkt_stat_counters`

## Requirements
- R1: The counters use this index order: 0 TX SOP, 1 TX EOP, 2 TX error, 3 RX SOP, 4 RX EOP, 5 RX error. Counter k has its low word (bits BUS_W-1:0) at word address 2k and its high word (bits CNT_W-1:BUS_W, zero-extended) at word address 2k+1. With READ_REG=0, rd_data follows rd_addr in the same cycle. With READ_REG=1, rd_data is registered and lags rd_addr by one cycle.
- R2: After reset, every counter word reads zero and snap_avail is 0.
- R3: A live counter rises by exactly one on each clock edge where its stream's valid and its own flag are both high. A flag seen while valid is low is not counted. In any other cycle the counter holds its value.
- R4: A snapshot request copies all six live counters into their shadows on the same edge. Reads return the shadow values, which stay unchanged until the next snapshot, even while the live counters keep counting.
- R5: Counting goes on through a snapshot. The shadow takes the value the counter had before that edge. An event in the snapshot cycle is still added to the live counter.
- R6: snap_avail goes to 1 on the edge after a snapshot request. It stays at 1 until a clear.
- R7: clear_req zeroes all live counters and all shadows and drops snap_avail. A clear wins over an event or a snapshot request in the same cycle.
- R8: pkt_end_clr has exactly the same effect as clear_req.
- R9: Counters wrap silently modulo 2^CNT_W.
- R10: Word addresses at or above 2 x 6 = 12 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit stream valid |
| tx_sop | input | 1 | Transmit start-of-packet flag |
| tx_eop | input | 1 | Transmit end-of-packet flag |
| tx_err | input | 1 | Transmit error flag |
| rx_valid | input | 1 | Receive stream valid |
| rx_sop | input | 1 | Receive start-of-packet flag |
| rx_eop | input | 1 | Receive end-of-packet flag |
| rx_err | input | 1 | Receive error flag |
| snap_req | input | 1 | Load all shadows from the live counters |
| clear_req | input | 1 | Zero the counters, the shadows and the flag |
| pkt_end_clr | input | 1 | End-of-packet clear, same effect as clear_req |
| rd_addr | input | ADDR_W | Counter word address |
| rd_data | output | BUS_W | Counter word read from the shadows |
| snap_avail | output | 1 | A snapshot is held |

## Verification
The assertions check on every cycle that each live counter either steps by one or holds, and that this matches its qualified event. They also check that a clear leaves counters, shadows and flag at zero, that a snapshot loads the shadows and that the shadows hold otherwise. Wrap to zero and zero reads at unmapped addresses are checked every cycle as well. The bench's scenarios cover what only the read port can show. These are the word placement of each counter, the value captured when an event coincides with a snapshot, totals after long mixed event streams, and the effect of each of the two clear inputs.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;
   localparam int NUM_CTR  = 6;
   localparam int WORDS_PC = 2;

   typedef enum logic [2:0] {
      CTR_TX_SOP = 3'd0,
      CTR_TX_EOP = 3'd1,
      CTR_TX_ERR = 3'd2,
      CTR_RX_SOP = 3'd3,
      CTR_RX_EOP = 3'd4,
      CTR_RX_ERR = 3'd5
   } ctr_idx_e;

   typedef struct packed {
      logic valid;
      logic sop;
      logic eop;
      logic err;
   } strobe_t;
endpackage

// File: rtl/pkt_stat_evq.sv
module pkt_stat_evq
   import pkt_stat_pkg::*;
(
   input  strobe_t              tx_stb,
   input  strobe_t              rx_stb,
   output logic [NUM_CTR-1:0]   inc_o
);
   always_comb begin
      inc_o             = '0;
      inc_o[CTR_TX_SOP] = tx_stb.valid & tx_stb.sop;
      inc_o[CTR_TX_EOP] = tx_stb.valid & tx_stb.eop;
      inc_o[CTR_TX_ERR] = tx_stb.valid & tx_stb.err;
      inc_o[CTR_RX_SOP] = rx_stb.valid & rx_stb.sop;
      inc_o[CTR_RX_EOP] = rx_stb.valid & rx_stb.eop;
      inc_o[CTR_RX_ERR] = rx_stb.valid & rx_stb.err;
   end
endmodule

// File: rtl/pkt_stat_cell.sv
module pkt_stat_cell #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic             snap_i,
   output logic [CNT_W-1:0] live_o,
   output logic [CNT_W-1:0] shadow_o
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_o <= '0;
      end else if (clr_i) begin
         live_o <= '0;
      end else if (inc_i) begin
         live_o <= live_o + STEP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_o <= '0;
      end else if (clr_i) begin
         shadow_o <= '0;
      end else if (snap_i) begin
         shadow_o <= live_o;
      end
   end
endmodule

// File: rtl/pkt_stat_rdmux.sv
module pkt_stat_rdmux #(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter int N_CTR    = 6,
   parameter int ADDR_W   = 4,
   parameter bit READ_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_CTR*CNT_W-1:0] shadow_flat,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [BUS_W-1:0]       rd_data
);
   localparam int HI_W      = CNT_W - BUS_W;
   localparam int NUM_WORDS = 2 * N_CTR;

   logic [BUS_W-1:0] words [NUM_WORDS];
   logic [BUS_W-1:0] sel_word;

   for (genvar k = 0; k < N_CTR; k++) begin : g_word
      assign words[2*k] = shadow_flat[k*CNT_W +: BUS_W];
      if (HI_W == BUS_W) begin : g_full_hi
         assign words[2*k+1] = shadow_flat[k*CNT_W+BUS_W +: HI_W];
      end else begin : g_pad_hi
         assign words[2*k+1] = {{(BUS_W-HI_W){1'b0}},
                                shadow_flat[k*CNT_W+BUS_W +: HI_W]};
      end
   end

   always_comb begin
      sel_word = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (int'(rd_addr) == w) sel_word = words[w];
      end
   end

   if (READ_REG) begin : g_reg_read
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= sel_word;
      end
   end else begin : g_comb_read
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rd_data    = sel_word;
   end
endmodule

// File: rtl/pkt_stat_counters.sv
module pkt_stat_counters
   import pkt_stat_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 4,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic              tx_sop,
   input  logic              tx_eop,
   input  logic              tx_err,
   input  logic              rx_valid,
   input  logic              rx_sop,
   input  logic              rx_eop,
   input  logic              rx_err,
   input  logic              snap_req,
   input  logic              clear_req,
   input  logic              pkt_end_clr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BUS_W-1:0]  rd_data,
   output logic              snap_avail
);
   localparam int NUM_WORDS = NUM_CTR * WORDS_PC;

   if (CNT_W <= BUS_W) begin : g_bad_narrow
      $error("CNT_W must exceed BUS_W");
   end
   if (CNT_W > 2 * BUS_W) begin : g_bad_wide
      $error("CNT_W must fit in two bus words");
   end
   if (ADDR_W < $clog2(NUM_WORDS)) begin : g_bad_addr
      $error("ADDR_W too small for the counter words");
   end

   strobe_t                    tx_stb, rx_stb;
   logic [NUM_CTR-1:0]         inc;
   logic                       clr_any;
   logic [NUM_CTR*CNT_W-1:0]   live_flat;
   logic [NUM_CTR*CNT_W-1:0]   shadow_flat;

   assign tx_stb  = '{valid: tx_valid, sop: tx_sop, eop: tx_eop, err: tx_err};
   assign rx_stb  = '{valid: rx_valid, sop: rx_sop, eop: rx_eop, err: rx_err};
   assign clr_any = clear_req | pkt_end_clr;

   pkt_stat_evq u_evq (
      .tx_stb (tx_stb),
      .rx_stb (rx_stb),
      .inc_o  (inc)
   );

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
      pkt_stat_cell #(.CNT_W(CNT_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr_i    (clr_any),
         .inc_i    (inc[k]),
         .snap_i   (snap_req),
         .live_o   (live_flat[k*CNT_W +: CNT_W]),
         .shadow_o (shadow_flat[k*CNT_W +: CNT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        snap_avail <= 1'b0;
      else if (clr_any)  snap_avail <= 1'b0;
      else if (snap_req) snap_avail <= 1'b1;
   end

   pkt_stat_rdmux #(
      .CNT_W    (CNT_W),
      .BUS_W    (BUS_W),
      .N_CTR    (NUM_CTR),
      .ADDR_W   (ADDR_W),
      .READ_REG (READ_REG)
   ) u_rdmux (
      .clk         (clk),
      .rst_n       (rst_n),
      .shadow_flat (shadow_flat),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );
endmodule

// File: rtl/pkt_stat_counters_chk.sv
module pkt_stat_counters_chk #(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 4,
   parameter bit READ_REG = 1'b1,
   parameter int N_CTR    = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   clr_any,
   input logic                   snap_req,
   input logic [N_CTR-1:0]       inc,
   input logic [N_CTR*CNT_W-1:0] live_flat,
   input logic [N_CTR*CNT_W-1:0] shadow_flat,
   input logic                   snap_avail,
   input logic [ADDR_W-1:0]      rd_addr,
   input logic [BUS_W-1:0]       rd_data
);
   localparam int NUM_WORDS = 2 * N_CTR;

   for (genvar k = 0; k < N_CTR; k++) begin : g_chk
      AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_any && inc[k]) |=> live_flat[k*CNT_W +: CNT_W] ==
            CNT_W'($past(live_flat[k*CNT_W +: CNT_W]) + 1'b1)); // R3
      AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_any && !inc[k]) |=> $stable(live_flat[k*CNT_W +: CNT_W])); // R3
      AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_any && inc[k] && (&live_flat[k*CNT_W +: CNT_W]))
            |=> live_flat[k*CNT_W +: CNT_W] == '0); // R9
   end

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any |=> (live_flat == '0 && shadow_flat == '0)); // R7
   AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any |=> !snap_avail); // R7
   AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_req && !clr_any) |=> shadow_flat == $past(live_flat)); // R4
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap_req && !clr_any) |=> $stable(shadow_flat)); // R4
   AST_SNAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_req && !clr_any) |=> snap_avail); // R6

   if (READ_REG) begin : g_rd_reg
      AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(rd_addr) >= NUM_WORDS) |=> rd_data == '0); // R10
   end else begin : g_rd_comb
      AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(rd_addr) >= NUM_WORDS) |-> rd_data == '0); // R10
   end
endmodule

bind pkt_stat_counters pkt_stat_counters_chk #(
   .CNT_W    (CNT_W),
   .BUS_W    (BUS_W),
   .ADDR_W   (ADDR_W),
   .READ_REG (READ_REG),
   .N_CTR    (pkt_stat_pkg::NUM_CTR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr_any     (clr_any),
   .snap_req    (snap_req),
   .inc         (inc),
   .live_flat   (live_flat),
   .shadow_flat (shadow_flat),
   .snap_avail  (snap_avail),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data)
);

// File: tb/pkt_stat_counters_bench.sv
`timescale 1ns/1ps
module pkt_stat_counters_bench;
   localparam int CNT_W  = 8;
   localparam int BUS_W  = 4;
   localparam int ADDR_W = 4;
   localparam int MASK   = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_valid = 0, tx_sop = 0, tx_eop = 0, tx_err = 0;
   logic rx_valid = 0, rx_sop = 0, rx_eop = 0, rx_err = 0;
   logic snap_req = 0, clear_req = 0, pkt_end_clr = 0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [BUS_W-1:0]  rd_data;
   logic              snap_avail;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int live_m [6];
   int shad_m [6];
   bit avail_m = 0;

   always #2 clk = ~clk;

   pkt_stat_counters #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .READ_REG(1'b0)
   ) u_pkt_stat_counters (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err),
      .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
      .snap_req(snap_req), .clear_req(clear_req), .pkt_end_clr(pkt_end_clr),
      .rd_addr(rd_addr), .rd_data(rd_data), .snap_avail(snap_avail)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ev bits: 0 tx_valid,1 tx_sop,2 tx_eop,3 tx_err,4 rx_valid,5 rx_sop,6 rx_eop,7 rx_err
   task automatic step(input logic [7:0] ev, input bit snap, input bit clr, input bit eclr);
      @(negedge clk);
      {rx_err, rx_eop, rx_sop, rx_valid, tx_err, tx_eop, tx_sop, tx_valid} = ev;
      snap_req = snap; clear_req = clr; pkt_end_clr = eclr;
      @(posedge clk);
      if (clr || eclr) begin
         for (int k = 0; k < 6; k++) begin live_m[k] = 0; shad_m[k] = 0; end
         avail_m = 0;
      end else begin
         if (snap) begin
            for (int k = 0; k < 6; k++) shad_m[k] = live_m[k];
            avail_m = 1;
         end
         for (int k = 0; k < 6; k++) begin
            bit hit;
            hit = (k < 3) ? (ev[0] & ev[1+k]) : (ev[4] & ev[2+k]);
            if (hit) live_m[k] = (live_m[k] + 1) & MASK;
         end
      end
   endtask

   task automatic idle();
      @(negedge clk);
      {rx_err, rx_eop, rx_sop, rx_valid, tx_err, tx_eop, tx_sop, tx_valid} = '0;
      snap_req = 0; clear_req = 0; pkt_end_clr = 0;
   endtask

   task automatic read_word(input int w, output int val);
      rd_addr = ADDR_W'(w);
      #0.2;
      val = int'(rd_data);
   endtask

   task automatic check_all(input string req);
      int lo, hi, got;
      for (int k = 0; k < 6; k++) begin
         read_word(2*k, lo);
         read_word(2*k+1, hi);
         got = (hi << BUS_W) | lo;
         chk(got == shad_m[k], req, got, shad_m[k]);
      end
      chk(snap_avail == avail_m, {req, " flag"}, int'(snap_avail), int'(avail_m));
   endtask

   initial begin
      int w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R2 reset");

      // R3 R5: every stimulus pattern, snapshots landing on active cycles
      for (int p = 0; p < 256; p++) step(8'(p), (p % 64) == 63, 0, 0);
      idle();
      check_all("R3 R5 sweep");

      // R4: counting continues, shadows stay put
      for (int i = 0; i < 20; i++) step(8'hFF, 0, 0, 0);
      idle();
      check_all("R4 hold");
      step(8'h00, 1, 0, 0);
      idle();
      check_all("R4 refresh");
      chk(snap_avail == 1'b1, "R6 flag set", int'(snap_avail), 1);

      // R3: flags without valid are ignored
      step(8'h00, 0, 1, 0);
      for (int i = 0; i < 10; i++) step(8'b1110_1110, 0, 0, 0);
      step(8'h00, 1, 0, 0);
      idle();
      check_all("R3 valid low");

      // R1: placement of RX error counter, high word in use
      step(8'h00, 0, 1, 0);
      for (int i = 0; i < 20; i++) step(8'b1001_0000, 0, 0, 0);
      step(8'h00, 1, 0, 0);
      idle();
      read_word(10, w); chk(w == 4, "R1 rx err low word", w, 4);
      read_word(11, w); chk(w == 1, "R1 rx err high word", w, 1);
      read_word(0, w);  chk(w == 0, "R1 tx sop low word", w, 0);
      check_all("R1 map");

      // R9: wrap
      step(8'h00, 0, 1, 0);
      for (int i = 0; i < 300; i++) step(8'b0000_0011, 0, 0, 0);
      step(8'h00, 1, 0, 0);
      idle();
      read_word(0, w); chk(w == (300 % 256) % 16, "R9 wrap low", w, 12);
      read_word(1, w); chk(w == (300 % 256) / 16, "R9 wrap high", w, 2);
      check_all("R9 wrap");

      // R7: clear beats events and snapshot
      for (int i = 0; i < 5; i++) step(8'hFF, 0, 0, 0);
      step(8'h00, 1, 0, 0);
      step(8'hFF, 1, 1, 0);
      idle();
      check_all("R7 clear wins");
      step(8'hFF, 0, 0, 0);
      step(8'h00, 1, 0, 0);
      idle();
      check_all("R7 restart");

      // R8: end-of-packet clear
      for (int i = 0; i < 7; i++) step(8'hFF, 0, 0, 0);
      step(8'hFF, 0, 0, 1);
      step(8'h00, 1, 0, 0);
      idle();
      check_all("R8 clear");
      step(8'h00, 0, 0, 1);
      idle();
      check_all("R8 flag drop");

      // R10: unmapped words
      for (int a = 12; a < 16; a++) begin
         read_word(a, w);
         chk(w == 0, "R10 unmapped", w, 0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule